// File: doc/BRIEF.md
# Serial Control-Word Register Port

This block accepts 16-bit control words from a host over a synchronous serial link and applies them to a small bank of 8-bit configuration registers. A one-cycle frame-sync pulse opens a frame. On each following shift strobe, one bit enters on the serial input, most significant bit first. At the same time, one bit leaves on the serial output. Everything runs on the master clock `mclk`, and the shift strobe is an enable that is synchronous to that clock.

Each word holds four fields. Bits 15..14 are two pass-through control bits. Bit 13 is the direction flag. Bits 12..8 are a 5-bit register address. Bits 7..0 are a data byte. When the direction flag is 0 (write), the data byte is loaded into the addressed register once the frame is complete. When the flag is 1 (read), the addressed register is returned in the last eight output bit slots of the same frame.

Address 0 is a no-op. It lets the host deliver control bits without changing any register. Register 1 sets a clock divider that derives a frame clock `fclk` from `mclk`.

Top module: `ctlword_port`

## Requirements
- R1: After reset, every register reads 0, `ctrl_bits` is 0 and `dout` is 0. Because register 1 is 0 and a zero divisor is treated as 1, `fclk` toggles on every `mclk` cycle.
- R2: A `fs` pulse opens a frame. The next 16 cycles with `shift_en` high each take one `din` bit, MSB first. The word layout is [15:14] control bits, [13] direction (0 = write, 1 = read), [12:8] address, [7:0] data. Strobes that arrive after the 16th bit and before the next `fs` are ignored.
- R3: A complete write frame to an implemented address (1 to NREG-1) loads bits [7:0] into that register. The register appears as byte `addr` of `cfg_regs` after the 16th bit.
- R4: In a write frame, `dout` is 0 for all 16 bit slots.
- R5: In a read frame, `dout` is 0 for the first 8 slots. It then carries the addressed register MSB first in the last 8 slots. The data field on `din` is ignored.
- R6: A read frame leaves every register unchanged.
- R7: Address 0 writes nothing and reads back as 0. Byte 0 of `cfg_regs` is always 0.
- R8: A write to an address of NREG or above is ignored, and a read from such an address returns 0.
- R9: A frame that gets a new `fs` before its 16th bit is discarded. No register and no control bit changes.
- R10: When a frame completes, in either direction and at any address, `ctrl_bits` takes the word's bits [15:14].
- R11: `fclk` has a 50% duty cycle, with each half-period lasting A `mclk` cycles, where A is register 1. A value of 0 counts as 1.
- R12: A new divisor takes effect only at the end of the half-period in progress, so the first `fclk` toggle after a write comes no later than the old half-period length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs | input | 1 | Frame-sync pulse; opens a new frame (takes priority over `shift_en`) |
| shift_en | input | 1 | Shift strobe, one bit per high cycle |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data to host (current bit slot) |
| ctrl_bits | output | 2 | Control bits of the last complete frame |
| cfg_regs | output | NREG*8 | Register bank, byte i = register i |
| fclk | output | 1 | Divided frame clock |

## Verification
The in-line assertions check the following on every cycle. `dout` stays low in the address half of a frame and throughout write frames. Registers change only on a completed write. A read or an aborted frame leaves the bank as it was. `fclk` toggles only at the divider's terminal count, and the active divisor changes only there. What the assertions cannot show is that the right byte returns from the right address, that the bit order is correct, and that the `fclk` half-periods have the right lengths, including the bounded delay before a new divisor takes effect. The bench's frame table and directed divider measurements cover those cases.

// File: rtl/ctlword_port.sv
module ctlword_port #(
  parameter int NREG = 4
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             fs,
  input  logic             shift_en,
  input  logic             din,
  output logic             dout,
  output logic [1:0]       ctrl_bits,
  output logic [NREG*8-1:0] cfg_regs,
  output logic             fclk
);
  localparam int IDX_W = (NREG > 2) ? $clog2(NREG) : 1;
  localparam int LAST  = 15;
  localparam int HALF  = 7;

  logic [14:0]            in_sr;
  logic [15:0]            out_sr;
  logic [4:0]             bit_cnt;
  logic                   active, rw_q;
  logic [NREG-1:0][7:0]   regs;
  logic [7:0]             div_cnt, a_act;

  wire [7:0]  hi   = {in_sr[6:0], din};
  wire [15:0] word = {in_sr[14:0], din};
  wire        shift  = active && shift_en && !fs;
  wire        at_hi  = shift && (bit_cnt == 5'(HALF));
  wire        at_end = shift && (bit_cnt == 5'(LAST));

  function automatic logic addr_ok(input logic [4:0] a);
    return (a != 5'd0) && (32'(a) < NREG);
  endfunction

  wire [7:0] rdata = addr_ok(hi[4:0]) ? regs[hi[IDX_W-1:0]] : 8'h00;
  wire       commit_wr = at_end && !word[13] && addr_ok(word[12:8]);

  always_ff @(posedge mclk) begin
    if (!rst_n) begin
      in_sr   <= '0;
      out_sr  <= '0;
      bit_cnt <= '0;
      active  <= 1'b0;
      rw_q    <= 1'b0;
    end else if (fs) begin
      out_sr  <= '0;
      bit_cnt <= '0;
      active  <= 1'b1;
      rw_q    <= 1'b0;
    end else if (shift) begin
      in_sr   <= word[14:0];
      bit_cnt <= bit_cnt + 5'd1;
      if (at_hi) begin
        rw_q   <= hi[5];
        out_sr <= {hi[5] ? rdata : 8'h00, 8'h00};
      end else begin
        out_sr <= {out_sr[14:0], 1'b0};
      end
      if (at_end) active <= 1'b0;
    end
  end

  always_ff @(posedge mclk) begin
    if (!rst_n) begin
      regs      <= '0;
      ctrl_bits <= '0;
    end else if (at_end) begin
      ctrl_bits <= word[15:14];
      if (commit_wr) regs[word[8+IDX_W-1:8]] <= word[7:0];
    end
  end

  assign dout     = out_sr[15];
  assign cfg_regs = regs;

  wire [7:0] a_next = (regs[1] == 8'd0) ? 8'd1 : regs[1];
  wire       tc     = (div_cnt == a_act - 8'd1);

  always_ff @(posedge mclk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      a_act   <= 8'd1;
      fclk    <= 1'b0;
    end else if (tc) begin
      div_cnt <= '0;
      a_act   <= a_next;
      fclk    <= ~fclk;
    end else begin
      div_cnt <= div_cnt + 8'd1;
    end
  end

  initial assert (NREG >= 2 && NREG <= 32);

  AST_HEAD_ZERO: assert property (@(posedge mclk) disable iff (!rst_n)
    active && bit_cnt <= 5'(HALF) |-> !dout); // R5
  AST_WRITE_ZERO: assert property (@(posedge mclk) disable iff (!rst_n)
    active && bit_cnt > 5'(HALF) && !rw_q |-> !dout); // R4
  AST_READ_KEEPS: assert property (@(posedge mclk) disable iff (!rst_n)
    at_end && word[13] |=> $stable(regs)); // R6
  AST_ONLY_ON_COMMIT: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(regs) |-> $past(commit_wr)); // R3
  AST_SLOT0_ZERO: assert property (@(posedge mclk) disable iff (!rst_n)
    cfg_regs[7:0] == 8'h00); // R7
  AST_ABORT_KEEPS: assert property (@(posedge mclk) disable iff (!rst_n)
    fs && active |=> $stable(regs) && $stable(ctrl_bits)); // R9
  AST_FCLK_AT_TC: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(fclk) |-> $past(div_cnt) == $past(a_act) - 8'd1); // R11
  AST_DIV_NONZERO: assert property (@(posedge mclk) disable iff (!rst_n)
    a_act != 8'd0 && div_cnt < a_act); // R11
  AST_SWAP_AT_TC: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(a_act) |-> !$stable(fclk)); // R12
endmodule

// File: tb/ctlword_port_tb.sv
module ctlword_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 4;
  localparam int NV = 11;
  // {word[15:0], expected dout word[15:0], expected ctrl[1:0]}
  localparam logic [33:0] VEC [NV] = '{
    {16'h4105, 16'h0000, 2'b01},   // R3 R4 write reg1=05
    {16'h02A5, 16'h0000, 2'b00},   // R3 write reg2=A5
    {16'hE2FF, 16'h00A5, 2'b11},   // R5 read reg2, data field ignored
    {16'h2100, 16'h0005, 2'b00},   // R5 read reg1
    {16'h8077, 16'h0000, 2'b10},   // R7 no-op write
    {16'h2000, 16'h0000, 2'b00},   // R7 no-op read
    {16'h0933, 16'h0000, 2'b00},   // R8 write unimplemented
    {16'h2900, 16'h0000, 2'b00},   // R8 read unimplemented
    {16'h03C3, 16'h0000, 2'b00},   // R3 write reg3
    {16'h6300, 16'h00C3, 2'b01},   // R5 read reg3
    {16'h2200, 16'h00A5, 2'b00}    // R6 reread reg2
  };

  logic mclk = 0, rst_n = 0, fs = 0, shift_en = 0, din = 0;
  logic dout, fclk;
  logic [1:0] ctrl_bits;
  logic [NREG*8-1:0] cfg_regs;
  int checks = 0, failures = 0;
  bit done = 0;

  ctlword_port #(.NREG(NREG)) dut_i (
    .mclk(mclk), .rst_n(rst_n), .fs(fs), .shift_en(shift_en), .din(din),
    .dout(dout), .ctrl_bits(ctrl_bits), .cfg_regs(cfg_regs), .fclk(fclk));

  always #(CLK_PERIOD/2) mclk = ~mclk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [15:0] w, input int nbits, output logic [15:0] got);
    got = '0;
    @(negedge mclk); fs = 1;
    @(negedge mclk); fs = 0;
    for (int i = 0; i < nbits; i++) begin
      din = w[15-i]; shift_en = 1;
      got[15-i] = dout;
      @(negedge mclk);
    end
    shift_en = 0; din = 0;
  endtask

  task automatic half_len(output int n);
    logic v;
    v = fclk; n = 0;
    do begin @(negedge mclk); n++; end while (fclk == v && n < 1000);
  endtask

  initial begin
    int n;
    logic [15:0] got;
    repeat (3) @(negedge mclk);
    rst_n = 1;
    @(negedge mclk);
    chk("R1 dout", 32'(dout), 0);
    chk("R1 ctrl", 32'(ctrl_bits), 0);
    chk("R1 regs", 32'(cfg_regs), 0);
    half_len(n); half_len(n);
    chk("R1 fclk half", n, 1);

    for (int k = 0; k < NV; k++) begin
      run_frame(VEC[k][33:18], 16, got);
      chk($sformatf("R2 R4 R5 dout vec%0d", k), 32'(got), 32'(VEC[k][17:2]));
      chk($sformatf("R10 ctrl vec%0d", k), 32'(ctrl_bits), 32'(VEC[k][1:0]));
    end
    chk("R3 R7 R8 regs", 32'(cfg_regs), 32'hC3A5_0500);

    run_frame(16'hC311, 10, got);
    run_frame(16'h2300, 16, got);
    chk("R9 short frame read", 32'(got), 32'h00C3);
    chk("R9 regs", 32'(cfg_regs), 32'hC3A5_0500);
    chk("R9 ctrl", 32'(ctrl_bits), 0);

    run_frame(16'h0207, 16, got);
    chk("R3 reg2 rewrite", 32'(cfg_regs), 32'hC307_0500);
    for (int i = 0; i < 3; i++) begin
      din = 1; shift_en = 1;
      chk("R2 extra strobe dout", 32'(dout), 0);
      @(negedge mclk);
    end
    shift_en = 0; din = 0;
    @(negedge mclk);
    chk("R2 extra strobes ignored", 32'(cfg_regs), 32'hC307_0500);

    run_frame(16'h0128, 16, got);
    half_len(n); half_len(n);
    chk("R11 half A=40", n, 40);
    half_len(n);
    chk("R11 duty A=40", n, 40);
    run_frame(16'h0102, 16, got);
    half_len(n);
    chk("R12 old half bounds swap", 32'(n <= 40), 1);
    half_len(n);
    chk("R12 new half A=2", n, 2);
    run_frame(16'h0100, 16, got);
    half_len(n); half_len(n);
    chk("R11 A=0 as 1", n, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge mclk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule